// File: doc/BRIEF.md
# Sync Frame Table Lock Controller

This block decides when application software may hold one of two sync frame tables (one for even-numbered communication cycles, one for odd) that a protocol engine copies into a shared memory area. The engine copies a table once per cycle pair. The copy runs in the network idle time that follows the static segment. An even cycle refreshes the even table and an odd cycle refreshes the odd one. Software claims a table by pulsing that table's lock trigger. It releases the table by pulsing the same trigger again.

A claim that arrives while its table is being copied is refused, and it is not remembered. Software must try again later. A claim against an idle table takes effect on the next clock edge. A held table is never overwritten. Its copy window is skipped and its valid flag keeps its previous value. Each table's valid flag rises when a copy finishes. Both valid flags drop when generation is off and the counter-update strobe fires, because the stored tables no longer match the counters.

Top module: `sync_table_guard`

## Requirements
- R1: After reset, both lock flags, both valid flags and both busy flags are 0.
- R2: A trigger pulse for an unlocked table whose busy flag is 0 sets that table's lock flag at the next clock edge.
- R3: A trigger pulse for an unlocked table whose busy flag is 1 is dropped. The lock flag stays 0 and no grant follows later unless the trigger is pulsed again.
- R4: A trigger pulse for a locked table clears its lock flag at the next clock edge.
- R5: With `gen_en`=1, a clock edge at which `seg_nit` is sampled 1 after being sampled 0 at the previous edge opens a copy window. The window is for the even table when `cyc_odd`=0 and for the odd table when `cyc_odd`=1. The busy flag of that table is then 1 for exactly WR_CLKS cycles, starting right after that edge.
- R6: The edge at which a copy's busy flag falls also sets that table's valid flag. The valid flag stays 0 during the copy if it was 0 before.
- R7: A window that opens for a locked table is skipped. Busy stays 0 and valid keeps its value.
- R8: If a trigger for an unlocked table and the opening of that table's window fall on the same edge, the lock is granted and the copy is skipped.
- R9: `cnt_upd`=1 while `gen_en`=0 clears both valid flags at the next edge, and this wins over a copy finishing at that edge. With `gen_en`=1, `cnt_upd` has no effect.
- R10: While `gen_en`=0, no copy window opens.
- R11: The two tables are independent. A trigger, a window or a busy copy on one table does not change the other table's lock or busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_nit | input | 1 | 1 during network idle time, 0 during the static segment |
| cyc_odd | input | 1 | Parity of the current cycle counter (1 = odd) |
| gen_en | input | 1 | Sync frame table generation enabled |
| cnt_upd | input | 1 | One-clock strobe: sync frame counters were refreshed |
| lock_trig_even | input | 1 | One-clock lock/unlock trigger for the even table |
| lock_trig_odd | input | 1 | One-clock lock/unlock trigger for the odd table |
| lock_even | output | 1 | Even table held by software |
| lock_odd | output | 1 | Odd table held by software |
| valid_even | output | 1 | Even table content matches the counters |
| valid_odd | output | 1 | Odd table content matches the counters |
| busy_even | output | 1 | Even table copy in progress |
| busy_odd | output | 1 | Odd table copy in progress |

## Verification
Directed sequences first take each table through a full copy. They then place a claim inside a running copy, so the refusal can be told apart from a delayed grant. They also claim on the exact edge a window opens, and they fire the counter strobe with generation off and with it on. After that, random segment lengths, cycle parity, triggers, strobes and generation toggles run against a cycle model in the bench. Triggers landing on the first and last busy cycles separate an off-by-one busy length from a correct one. Claims on one table during the other table's copy show whether the two tables are kept apart.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int NUM_TBL = 2;

  typedef enum logic {
    TBL_EVEN = 1'b0,
    TBL_ODD  = 1'b1
  } tbl_e;

  // A copy window opens on the first idle-time sample after the static segment.
  function automatic logic win_opens(logic prev_nit, logic cur_nit, logic gen);
    return gen & cur_nit & ~prev_nit;
  endfunction

  function automatic tbl_e tbl_of(logic odd);
    return odd ? TBL_ODD : TBL_EVEN;
  endfunction
endpackage

// File: rtl/sft_window_detect.sv
module sft_window_detect
  import sft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_nit,
  input  logic               cyc_odd,
  input  logic               gen_en,
  output logic [NUM_TBL-1:0] start_o
);
  logic nit_q;
  logic open_w;
  tbl_e sel_w;

  // Reset to "idle" so a block leaving reset inside idle time does not open a window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nit_q <= 1'b1;
    else        nit_q <= seg_nit;
  end

  assign open_w = win_opens(nit_q, seg_nit, gen_en);
  assign sel_w  = tbl_of(cyc_odd);

  assign start_o[TBL_EVEN] = open_w & (sel_w == TBL_EVEN);
  assign start_o[TBL_ODD]  = open_w & (sel_w == TBL_ODD);

  // R5: a window targets exactly one table
  a_r5_one_table_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  // R10: no window while generation is off
  a_r10_no_window_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (start_o == '0));
endmodule

// File: rtl/sft_write_timer.sv
module sft_write_timer #(
  parameter int WR_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WR_CLKS + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] cnt_step(logic ld, logic [CW-1:0] c);
    if (ld)       return CW'(WR_CLKS);
    if (c != '0)  return c - CW'(1);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_step(load_i, cnt_q);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  // R5: an accepted copy is busy from the next cycle
  a_r5_load_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);

  // R6: the last busy cycle is followed by idle
  a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> !busy_o);
endmodule

// File: rtl/sft_table_lock.sv
module sft_table_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic start_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic clr_i,
  output logic lock_o,
  output logic valid_o,
  output logic accept_o
);
  logic lock_q, valid_q;
  logic grant_w, release_w, refuse_w;

  assign release_w = trig_i & lock_q;
  assign grant_w   = trig_i & ~lock_q & ~busy_i;
  assign refuse_w  = trig_i & ~lock_q & busy_i;

  // A held table, or one being claimed on this edge, skips its window.
  assign accept_o  = start_i & ~lock_q & ~trig_i;

  function automatic logic next_lock(logic cur, logic grant, logic rel);
    if (rel)   return 1'b0;
    if (grant) return 1'b1;
    return cur;
  endfunction

  function automatic logic next_valid(logic cur, logic done, logic clr);
    if (clr)  return 1'b0;
    if (done) return 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      lock_q  <= next_lock(lock_q, grant_w, release_w);
      valid_q <= next_valid(valid_q, done_i, clr_i);
    end
  end

  assign lock_o  = lock_q;
  assign valid_o = valid_q;

  // R2: idle table is granted on the next edge
  a_r2_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |=> lock_o);

  // R3: claim during a copy is dropped
  a_r3_refuse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_w |=> !lock_o);

  // R4: trigger on a held table releases it
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && lock_o |=> !lock_o);

  // R7: a held table keeps its valid flag across its window
  a_r7_locked_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o && start_i && !done_i && !clr_i |=> $stable(valid_o));

  // R6: finished copy marks the table valid
  a_r6_done_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !clr_i |=> valid_o);

  // R9: stale tables are invalidated
  a_r9_clear_valid: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !valid_o);
endmodule

// File: rtl/sync_table_guard.sv
module sync_table_guard
  import sft_pkg::*;
#(
  parameter int WR_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_nit,
  input  logic cyc_odd,
  input  logic gen_en,
  input  logic cnt_upd,
  input  logic lock_trig_even,
  input  logic lock_trig_odd,
  output logic lock_even,
  output logic lock_odd,
  output logic valid_even,
  output logic valid_odd,
  output logic busy_even,
  output logic busy_odd
);
  logic [NUM_TBL-1:0] start_w, trig_w, accept_w, busy_w, done_w, lock_w, valid_w;
  logic               clr_w;

  assign trig_w[TBL_EVEN] = lock_trig_even;
  assign trig_w[TBL_ODD]  = lock_trig_odd;
  assign clr_w            = ~gen_en & cnt_upd;

  sft_window_detect i_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_nit (seg_nit),
    .cyc_odd (cyc_odd),
    .gen_en  (gen_en),
    .start_o (start_w)
  );

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    sft_write_timer #(.WR_CLKS(WR_CLKS)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept_w[g]),
      .busy_o (busy_w[g]),
      .done_o (done_w[g])
    );

    sft_table_lock i_lck (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_i   (trig_w[g]),
      .start_i  (start_w[g]),
      .busy_i   (busy_w[g]),
      .done_i   (done_w[g]),
      .clr_i    (clr_w),
      .lock_o   (lock_w[g]),
      .valid_o  (valid_w[g]),
      .accept_o (accept_w[g])
    );

    // R7: a table is never held and being copied at once
    a_r7_lock_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_w[g] && busy_w[g]));
  end

  assign lock_even  = lock_w[TBL_EVEN];
  assign lock_odd   = lock_w[TBL_ODD];
  assign valid_even = valid_w[TBL_EVEN];
  assign valid_odd  = valid_w[TBL_ODD];
  assign busy_even  = busy_w[TBL_EVEN];
  assign busy_odd   = busy_w[TBL_ODD];
endmodule

// File: tb/test_sync_table_guard.sv
`timescale 1ns/1ps
module test_sync_table_guard;
  localparam int W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, seg_nit, cyc_odd, gen_en, cnt_upd, trig_e, trig_o;
  logic lock_even, lock_odd, valid_even, valid_odd, busy_even, busy_odd;

  sync_table_guard #(.WR_CLKS(W)) i_sync_table_guard (
    .clk(clk), .rst_n(rst_n), .seg_nit(seg_nit), .cyc_odd(cyc_odd),
    .gen_en(gen_en), .cnt_upd(cnt_upd),
    .lock_trig_even(trig_e), .lock_trig_odd(trig_o),
    .lock_even(lock_even), .lock_odd(lock_odd),
    .valid_even(valid_even), .valid_odd(valid_odd),
    .busy_even(busy_even), .busy_odd(busy_odd)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // Bench model: remaining copy cycles per table, counted from requirements.
  bit m_lock[2], m_valid[2];
  int m_left[2];
  bit m_prev;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit opens(bit prev, bit cur, bit gen);
    return gen && cur && !prev;
  endfunction

  task automatic model_step();
    bit op, clr;
    bit t[2];
    t[0] = trig_e; t[1] = trig_o;
    op  = opens(m_prev, seg_nit, gen_en);
    clr = !gen_en && cnt_upd;
    for (int i = 0; i < 2; i++) begin
      bit fin, take;
      fin  = (m_left[i] == 1);
      take = op && (int'(cyc_odd) == i) && !m_lock[i] && !t[i];
      if (t[i]) m_lock[i] = m_lock[i] ? 1'b0 : (m_left[i] == 0);
      m_left[i] = take ? W : (m_left[i] > 0 ? m_left[i] - 1 : 0);
      if (clr) m_valid[i] = 1'b0;
      else if (fin) m_valid[i] = 1'b1;
    end
    m_prev = seg_nit;
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 lock_even", lock_even, m_lock[0]);
    chk("R2 R3 R4 lock_odd",  lock_odd,  m_lock[1]);
    chk("R5 R7 R10 busy_even", busy_even, m_left[0] > 0);
    chk("R5 R7 R10 busy_odd",  busy_odd,  m_left[1] > 0);
    chk("R6 R9 valid_even", valid_even, m_valid[0]);
    chk("R6 R9 valid_odd",  valid_odd,  m_valid[1]);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    trig_e = 0; trig_o = 0; cnt_upd = 0;
  endtask

  task automatic open_window(bit odd);
    seg_nit = 0; cyc_odd = odd; cycle();
    seg_nit = 1; cycle();
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int seg_left;
    rst_n = 0; seg_nit = 0; cyc_odd = 0; gen_en = 1; cnt_upd = 0; trig_e = 0; trig_o = 0;
    m_lock = '{0, 0}; m_valid = '{0, 0}; m_left = '{0, 0}; m_prev = 1;
    repeat (3) @(negedge clk);
    chk("R1 lock_even", lock_even, 0); chk("R1 lock_odd", lock_odd, 0);
    chk("R1 valid_even", valid_even, 0); chk("R1 valid_odd", valid_odd, 0);
    chk("R1 busy_even", busy_even, 0); chk("R1 busy_odd", busy_odd, 0);
    rst_n = 1;

    // R5 R6: full even copy
    open_window(0);
    chk("R5 busy starts", busy_even, 1);
    chk("R11 odd idle", busy_odd, 0);
    repeat (W - 1) cycle();
    chk("R5 busy last cycle", busy_even, 1);
    chk("R6 valid not yet", valid_even, 0);
    cycle();
    chk("R6 valid set", valid_even, 1);
    chk("R5 busy length", busy_even, 0);

    // R3 R11: claim odd during its copy, claim even meanwhile
    seg_nit = 0; cycle();
    open_window(1);
    trig_o = 1; trig_e = 1; cycle();
    chk("R3 refused", lock_odd, 0);
    chk("R11 other table granted", lock_even, 1);
    repeat (W + 2) cycle();
    chk("R3 no late grant", lock_odd, 0);
    chk("R6 odd valid", valid_odd, 1);

    // R7: even held, its window skipped
    seg_nit = 0; cycle();
    open_window(0);
    chk("R7 no busy", busy_even, 0);
    chk("R7 valid kept", valid_even, 1);

    // R4: release
    trig_e = 1; cycle();
    chk("R4 released", lock_even, 0);

    // R8: claim on the opening edge
    seg_nit = 0; cyc_odd = 0; cycle();
    seg_nit = 1; trig_e = 1; cycle();
    chk("R8 lock wins", lock_even, 1);
    chk("R8 copy skipped", busy_even, 0);
    trig_e = 1; cycle();
    chk("R4 released again", lock_even, 0);

    // R9 with generation on: no effect
    cnt_upd = 1; cycle();
    chk("R9 no clear when enabled", valid_odd, 1);

    // R10 R9: generation off
    gen_en = 0;
    seg_nit = 0; cycle();
    open_window(1);
    chk("R10 no window", busy_odd, 0);
    cnt_upd = 1; cycle();
    chk("R9 cleared even", valid_even, 0);
    chk("R9 cleared odd", valid_odd, 0);
    gen_en = 1;

    // Random phase
    void'($urandom(32'd1234));
    seg_left = 1;
    for (int k = 0; k < 4000; k++) begin
      seg_left--;
      if (seg_left <= 0) begin
        if (seg_nit) cyc_odd = ~cyc_odd;
        seg_nit = ~seg_nit;
        seg_left = 1 + int'($urandom % (W + 6));
      end
      trig_e  = ($urandom % 6) == 0;
      trig_o  = ($urandom % 6) == 0;
      cnt_upd = ($urandom % 12) == 0;
      if (($urandom % 40) == 0) gen_en = ~gen_en;
      cycle();
    end
    report();
  end
endmodule